// File: doc/BRIEF.md
# Byte-Serial Unsigned String Compare Engine

This block compares two byte fields held in storage and reports how they order. It works one byte pair per clock, starting at each field's lowest address and moving upward, and it treats every byte as an unsigned number. The first pair that differs decides the result, and the engine stops there. A second mode compares a single storage byte with an 8-bit value supplied alongside the start command.

A controller pulses the start input once. With the start it supplies the mode, the two field addresses, a length code equal to the byte count minus one, and the immediate byte. The engine drives one synchronous read port per operand. Each read returns its data one cycle after it is issued. When the result is known, the engine pulses done for one cycle and holds the condition code until the next completion. Storage, address translation and instruction decoding sit outside the block.

Top module: `bytecmp_engine`

## Requirements
- R1: While reset is held and after it is released, done_o, both read enables and cc_o are all 0 until a start is accepted.
- R2: Bytes are ordered as unsigned values. For example, 0x80 against 0x7F gives "first high" (2), and 0x01 against 0xFF gives "first low" (1).
- R3: The condition code is 0 when the fields are equal, 1 when the first operand is lower and 2 when it is higher. The value 3 never appears.
- R4: In field mode (imm_mode_i = 0), len_code_i = L compares L+1 byte pairs at offsets 0, 1, ..., L in ascending order. Code 0 compares 1 pair and code 255 compares 256 pairs.
- R5: The first unequal pair decides the code, and no pair after it affects the result.
- R6: In immediate mode (imm_mode_i = 1), exactly one byte is read from addr_a_i and compared with imm_byte_i. Operand B is never read, and len_code_i has no effect.
- R7: In field mode, every operand-A read is paired with an operand-B read in the same cycle at the same offset from its own start address.
- R8: done_o is a single-cycle pulse. If the start is sampled in cycle t and m pairs are examined, done_o and the new cc_o appear in cycle t+m+2.
- R9: A start pulse while a comparison is in progress is ignored. It produces no extra completion and does not change the running comparison.
- R10: The engine issues exactly m reads per port for a comparison that examines m pairs. No read goes past the deciding pair or beyond offset L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| imm_mode_i | input | 1 | 1 = immediate compare, 0 = field compare |
| addr_a_i | input | ADDR_W | Start address of the first operand |
| addr_b_i | input | ADDR_W | Start address of the second operand |
| len_code_i | input | LEN_W | Byte count minus one (field mode) |
| imm_byte_i | input | 8 | Immediate comparand |
| rd_a_en_o | output | 1 | Operand-A read request |
| rd_a_addr_o | output | ADDR_W | Operand-A read address |
| rd_a_data_i | input | 8 | Operand-A data, one cycle after the request |
| rd_b_en_o | output | 1 | Operand-B read request |
| rd_b_addr_o | output | ADDR_W | Operand-B read address |
| rd_b_data_i | input | 8 | Operand-B data, one cycle after the request |
| cc_o | output | 2 | Condition code of the last completed compare |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The test fields are chosen to separate the outcomes that an incorrect design would merge:
- Fully equal fields of 4 and 256 bytes test the length decode and the full-length path.
- A mismatch on the first byte, in the middle and on the last byte tests where the engine stops. The middle mismatch is followed by an opposite-ordered pair, so a design that keeps scanning would report the wrong code.
- Byte pairs that straddle 0x80 separate an unsigned comparison from a signed one.
- A length code of 0 placed in front of a differing second byte separates one pair from two.
- Immediate compares for equal, low and high, with operand B deliberately unequal and a large length code, show that B and the length are ignored.
- A second start pulse in the middle of a run checks that the running comparison is left untouched.

// File: rtl/bce_pkg.sv
package bce_pkg;

  typedef enum logic [1:0] {
    CC_EQUAL      = 2'd0,
    CC_FIRST_LOW  = 2'd1,
    CC_FIRST_HIGH = 2'd2
  } cc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // Unsigned ordering of one byte pair.
  function automatic cc_e byte_order(input logic [7:0] first, input logic [7:0] second);
    if (first == second)     return CC_EQUAL;
    else if (first < second) return CC_FIRST_LOW;
    else                     return CC_FIRST_HIGH;
  endfunction

endpackage

// File: rtl/bce_operand_fetch.sv
module bce_operand_fetch #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_a_in,
  input  logic [ADDR_W-1:0] base_b_in,
  input  logic [LEN_W-1:0]  last_in,
  input  logic              imm_mode_in,
  input  logic              advance,
  output logic              issue,
  output logic              issue_last,
  output logic              rd_a_en,
  output logic [ADDR_W-1:0] rd_a_addr,
  output logic              rd_b_en,
  output logic [ADDR_W-1:0] rd_b_addr,
  output logic [ADDR_W-1:0] base_a_q,
  output logic [ADDR_W-1:0] base_b_q,
  output logic [LEN_W-1:0]  last_q,
  output logic              imm_mode_q
);

  localparam int PAD_W = ADDR_W - LEN_W;

  logic [LEN_W-1:0]  idx_q;
  logic              all_issued_q;
  logic [ADDR_W-1:0] offset;

  assign offset     = {{PAD_W{1'b0}}, idx_q};
  assign issue      = advance && !all_issued_q;
  assign issue_last = issue && (idx_q == last_q);

  assign rd_a_en   = issue;
  assign rd_a_addr = base_a_q + offset;
  assign rd_b_en   = issue && !imm_mode_q;
  assign rd_b_addr = base_b_q + offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a_q     <= '0;
      base_b_q     <= '0;
      last_q       <= '0;
      imm_mode_q   <= 1'b0;
      idx_q        <= '0;
      all_issued_q <= 1'b1;
    end else if (load) begin
      base_a_q     <= base_a_in;
      base_b_q     <= base_b_in;
      last_q       <= last_in;
      imm_mode_q   <= imm_mode_in;
      idx_q        <= '0;
      all_issued_q <= 1'b0;
    end else if (issue) begin
      if (issue_last) all_issued_q <= 1'b1;
      else            idx_q        <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/bce_byte_judge.sv
module bce_byte_judge
  import bce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] imm_byte_in,
  input  logic       imm_mode,
  input  logic       issue,
  input  logic       issue_last,
  input  logic [7:0] data_a,
  input  logic [7:0] data_b,
  output logic       decide,
  output logic [1:0] cc_now
);

  logic       pend_q;
  logic       pend_last_q;
  logic [7:0] imm_q;
  logic [7:0] second;
  logic       mismatch;
  cc_e        order;

  assign second   = imm_mode ? imm_q : data_b;
  assign order    = byte_order(data_a, second);
  assign mismatch = pend_q && (order != CC_EQUAL);
  assign decide   = pend_q && (mismatch || pend_last_q);
  assign cc_now   = order;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
      imm_q       <= '0;
    end else begin
      pend_q      <= issue;
      pend_last_q <= issue_last;
      if (load) imm_q <= imm_byte_in;
    end
  end

endmodule

// File: rtl/bce_sequencer.sv
module bce_sequencer
  import bce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       decide,
  input  logic [1:0] cc_now,
  output logic       load,
  output logic       busy,
  output logic       advance,
  output logic       done,
  output logic [1:0] cc
);

  seq_state_e state_q;

  assign busy    = (state_q == ST_RUN);
  assign load    = (state_q == ST_IDLE) && start;
  assign advance = busy && !decide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      cc      <= CC_EQUAL;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_RUN;
        ST_RUN: begin
          if (decide) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            cc      <= cc_now;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bytecmp_engine.sv
module bytecmp_engine #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              imm_mode_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [LEN_W-1:0]  len_code_i,
  input  logic [7:0]        imm_byte_i,
  output logic              rd_a_en_o,
  output logic [ADDR_W-1:0] rd_a_addr_o,
  input  logic [7:0]        rd_a_data_i,
  output logic              rd_b_en_o,
  output logic [ADDR_W-1:0] rd_b_addr_o,
  input  logic [7:0]        rd_b_data_i,
  output logic [1:0]        cc_o,
  output logic              done_o
);

  // Internal events brought out as named wires for the checker.
  logic              load;
  logic              busy;
  logic              advance;
  logic              issue;
  logic              issue_last;
  logic              decide;
  logic [1:0]        cc_now;
  logic [LEN_W-1:0]  last_in;
  logic [ADDR_W-1:0] base_a_q;
  logic [ADDR_W-1:0] base_b_q;
  logic [LEN_W-1:0]  last_q;
  logic              imm_mode_q;

  // Immediate mode always examines exactly one pair.
  assign last_in = imm_mode_i ? '0 : len_code_i;

  bce_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .decide  (decide),
    .cc_now  (cc_now),
    .load    (load),
    .busy    (busy),
    .advance (advance),
    .done    (done_o),
    .cc      (cc_o)
  );

  bce_operand_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .base_a_in   (addr_a_i),
    .base_b_in   (addr_b_i),
    .last_in     (last_in),
    .imm_mode_in (imm_mode_i),
    .advance     (advance),
    .issue       (issue),
    .issue_last  (issue_last),
    .rd_a_en     (rd_a_en_o),
    .rd_a_addr   (rd_a_addr_o),
    .rd_b_en     (rd_b_en_o),
    .rd_b_addr   (rd_b_addr_o),
    .base_a_q    (base_a_q),
    .base_b_q    (base_b_q),
    .last_q      (last_q),
    .imm_mode_q  (imm_mode_q)
  );

  bce_byte_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .imm_byte_in (imm_byte_i),
    .imm_mode    (imm_mode_q),
    .issue       (issue),
    .issue_last  (issue_last),
    .data_a      (rd_a_data_i),
    .data_b      (rd_b_data_i),
    .decide      (decide),
    .cc_now      (cc_now)
  );

endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy,
  input logic              done_o,
  input logic [1:0]        cc_o,
  input logic              rd_a_en_o,
  input logic              rd_b_en_o,
  input logic [ADDR_W-1:0] rd_a_addr_o,
  input logic [ADDR_W-1:0] rd_b_addr_o,
  input logic [ADDR_W-1:0] base_a_q,
  input logic [ADDR_W-1:0] base_b_q,
  input logic [LEN_W-1:0]  last_q,
  input logic              imm_mode_q
);

  localparam int PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] off_a;
  logic [ADDR_W-1:0] off_b;
  logic [ADDR_W-1:0] last_wide;

  assign off_a     = rd_a_addr_o - base_a_q;
  assign off_b     = rd_b_addr_o - base_b_q;
  assign last_wide = {{PAD_W{1'b0}}, last_q};

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_a_en_o && !rd_b_en_o));

  assert_cc_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cc_o != 2'd3));

  assert_imm_no_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && imm_mode_q) |-> !rd_b_en_o);

  assert_pair_lockstep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !imm_mode_q) |-> (rd_a_en_o == rd_b_en_o));

  assert_same_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_en_o |-> (off_a == off_b));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ($stable(base_a_q) && $stable(last_q) && $stable(imm_mode_q)));

  assert_within_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_en_o |-> (off_a <= last_wide));

endmodule

bind bytecmp_engine bce_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy        (busy),
  .done_o      (done_o),
  .cc_o        (cc_o),
  .rd_a_en_o   (rd_a_en_o),
  .rd_b_en_o   (rd_b_en_o),
  .rd_a_addr_o (rd_a_addr_o),
  .rd_b_addr_o (rd_b_addr_o),
  .base_a_q    (base_a_q),
  .base_b_q    (base_b_q),
  .last_q      (last_q),
  .imm_mode_q  (imm_mode_q)
);

// File: tb/test_bytecmp_engine.sv
module test_bytecmp_engine;

  localparam int ADDR_W = 12;
  localparam int LEN_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              imm_mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_a_i = '0;
  logic [ADDR_W-1:0] addr_b_i = '0;
  logic [LEN_W-1:0]  len_code_i = '0;
  logic [7:0]        imm_byte_i = '0;
  logic              rd_a_en_o, rd_b_en_o;
  logic [ADDR_W-1:0] rd_a_addr_o, rd_b_addr_o;
  logic [7:0]        rd_a_data_i = '0;
  logic [7:0]        rd_b_data_i = '0;
  logic [1:0]        cc_o;
  logic              done_o;

  always #5 clk = ~clk;

  bytecmp_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_bytecmp_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .imm_mode_i(imm_mode_i),
    .addr_a_i(addr_a_i), .addr_b_i(addr_b_i), .len_code_i(len_code_i),
    .imm_byte_i(imm_byte_i), .rd_a_en_o(rd_a_en_o), .rd_a_addr_o(rd_a_addr_o),
    .rd_a_data_i(rd_a_data_i), .rd_b_en_o(rd_b_en_o), .rd_b_addr_o(rd_b_addr_o),
    .rd_b_data_i(rd_b_data_i), .cc_o(cc_o), .done_o(done_o)
  );

  // Storage models with one cycle of read latency.
  logic [7:0] mem_a [DEPTH];
  logic [7:0] mem_b [DEPTH];
  always @(posedge clk) begin
    if (rd_a_en_o) rd_a_data_i <= mem_a[rd_a_addr_o];
    if (rd_b_en_o) rd_b_data_i <= mem_b[rd_b_addr_o];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0] cc;
    int         when;
    int         reads;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  // Current-operation context for the read monitor.
  int  cur_ba, cur_bb, cur_last, next_off;
  bit  cur_imm;
  bit  rd_bad;
  int  stray_done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: read pattern tracking and scoreboard pop.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_a_en_o) begin
        if (((int'(rd_a_addr_o) - cur_ba) & (DEPTH-1)) != next_off || next_off > cur_last) rd_bad = 1'b1;
        if (cur_imm) begin
          if (rd_b_en_o) rd_bad = 1'b1;
        end else if (!rd_b_en_o || ((int'(rd_b_addr_o) - cur_bb) & (DEPTH-1)) != next_off) begin
          rd_bad = 1'b1;
        end
        next_off++;
      end else if (rd_b_en_o) begin
        rd_bad = 1'b1;
      end
      if (done_o) begin
        if (exp_q.size() == 0) begin
          stray_done++;
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cc_o == e.cc, e.req, "condition code", cc_o, e.cc);
          check(cyc == e.when, "R8", "completion cycle", cyc, e.when);
          check(!rd_bad && next_off == e.reads, "R10", "reads issued (R7 pairing)", next_off, e.reads);
        end
      end
    end
  end

  task automatic fill(input int ba, input int bb, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      mem_a[(ba+i) % DEPTH] = 8'((i*37 + seed) & 255);
      mem_b[(bb+i) % DEPTH] = 8'((i*37 + seed) & 255);
    end
  endtask

  // Driver: computes the expected result from the requirements and pushes it.
  task automatic launch(input bit imm, input int ba, input int bb, input int lenc,
                        input logic [7:0] imm_b, input string req);
    exp_t e;
    int   m = 0;
    logic [1:0] c = 2'd0;
    if (imm) begin
      m = 1;
      if (mem_a[ba] != imm_b) c = (mem_a[ba] < imm_b) ? 2'd1 : 2'd2;
    end else begin
      for (int i = 0; i <= lenc; i++) begin
        logic [7:0] x, y;
        x = mem_a[(ba+i) % DEPTH];
        y = mem_b[(bb+i) % DEPTH];
        m = i + 1;
        if (x != y) begin
          c = (x < y) ? 2'd1 : 2'd2;
          break;
        end
      end
    end
    @(negedge clk);
    imm_mode_i = imm; addr_a_i = ADDR_W'(ba); addr_b_i = ADDR_W'(bb);
    len_code_i = LEN_W'(lenc); imm_byte_i = imm_b; start_i = 1'b1;
    cur_imm = imm; cur_ba = ba; cur_bb = bb; cur_last = imm ? 0 : lenc;
    next_off = 0; rd_bad = 1'b0;
    e.cc = c; e.when = cyc + m + 2; e.reads = m; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_op();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic run(input bit imm, input int ba, input int bb, input int lenc,
                     input logic [7:0] imm_b, input string req);
    launch(imm, ba, bb, lenc, imm_b, req);
    finish_op();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem_a[i] = 8'h00; mem_b[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    check(!done_o && cc_o == 2'd0 && !rd_a_en_o && !rd_b_en_o, "R1", "outputs in reset",
          {done_o, cc_o, rd_a_en_o, rd_b_en_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done_o && cc_o == 2'd0 && !rd_a_en_o && !rd_b_en_o, "R1", "outputs after reset",
          {done_o, cc_o, rd_a_en_o, rd_b_en_o}, 0);

    // R3/R4: equal four-byte fields
    fill('h100, 'h800, 32, 5);
    run(0, 'h100, 'h800, 3, 8'h00, "R3");

    // R3/R5: first byte lower
    mem_a['h100] = 8'h10; mem_b['h800] = 8'h20;
    run(0, 'h100, 'h800, 9, 8'h00, "R3");

    // R5: middle mismatch high, later pair reversed
    fill('h100, 'h800, 32, 5);
    mem_a['h105] = 8'h90; mem_b['h805] = 8'h30;
    mem_a['h106] = 8'h00; mem_b['h806] = 8'hFF;
    run(0, 'h100, 'h800, 9, 8'h00, "R5");

    // R2: unsigned ordering around 0x80
    fill('h100, 'h800, 32, 5);
    mem_a['h100] = 8'h80; mem_b['h800] = 8'h7F;
    run(0, 'h100, 'h800, 3, 8'h00, "R2");
    mem_a['h100] = 8'h01; mem_b['h800] = 8'hFF;
    run(0, 'h100, 'h800, 3, 8'h00, "R2");

    // R4: length code 0 examines only one pair
    fill('h100, 'h800, 32, 5);
    mem_a['h101] = 8'h00; mem_b['h801] = 8'h01;
    run(0, 'h100, 'h800, 0, 8'h00, "R4");

    // R4: full 256-byte field, equal then last-byte low
    fill('h200, 'h400, 256, 11);
    run(0, 'h200, 'h400, 255, 8'h00, "R4");
    mem_a['h2FF] = 8'h00; mem_b['h4FF] = 8'h01;
    run(0, 'h200, 'h400, 255, 8'h00, "R4");

    // R6: immediate compare, B unequal and length code ignored
    mem_a['h300] = 8'h5A; mem_b['h300] = 8'h00;
    run(1, 'h300, 'h300, 200, 8'h5A, "R6");
    run(1, 'h300, 'h300, 200, 8'h5B, "R6");
    run(1, 'h300, 'h300, 7,   8'h00, "R6");
    mem_a['h300] = 8'h80;
    run(1, 'h300, 'h300, 0,   8'h7F, "R2");

    // R9: second start mid-run must be ignored
    fill('h200, 'h400, 256, 11);
    mem_a['h300] = 8'h00;
    launch(0, 'h200, 'h400, 40, 8'h00, "R9");
    repeat (5) @(negedge clk);
    imm_mode_i = 1'b1; addr_a_i = 'h300; imm_byte_i = 8'hFF; len_code_i = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_op();
    repeat (20) @(negedge clk);
    check(stray_done == 0, "R9", "extra completions", stray_done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule